// File: doc/BRIEF.md
# Floating-Point Register File with Precision-Aligned Operands

The block is the register store of a floating-point unit: thirty-two 32-bit registers that are read and written as single, double or extended operands. A double operand spans two consecutive registers starting at an even number. An extended operand spans four consecutive registers starting at a multiple of four. Each access names a base register and a precision, and moves 32, 64 or 128 bits built from those registers.

There are two independent combinational read ports and one clocked write port. These ports are the only path into and out of the store. Nothing on the integer side can reach the registers. Every port first checks a unit enable bit, the precision code and the base-register alignment. A failing access is not performed, and its port reports a status code.

The block is used as the load/store end of the floating-point datapath. A load writes through the write port. A store or an operand fetch reads through port A or port B.

Top module: `fprf_top`

## Requirements
- R1: The store holds NUM_REGS (32) registers of 32 bits. Reset (rst_ni low) clears every register to zero.
- R2: The precision code is 2 bits wide: 00 is single, 01 is double, 10 is extended and 11 is reserved. A single read on port A or port B returns the named register in data bits [31:0], with the upper bits zero. The two read ports are independent of each other.
- R3: A double read at base n returns register n in bits [63:32] and register n+1 in bits [31:0]. Bits [127:64] are zero.
- R4: An extended read at base n returns register n in [127:96], n+1 in [95:64], n+2 in [63:32] and n+3 in [31:0].
- R5: A write uses the same bit placement as a read of the same precision. All registers of the group update on the same rising clock edge.
- R6: A read in the same cycle as a write to an overlapping register returns the contents from before the write. The new value is readable after the edge.
- R7: When fp_en_i is 0, every requested access reports status 01 (disabled trap). The read data is zero and no register changes.
- R8: A request with the reserved precision 11 reports status 11 (illegal operand) and performs no access.
- R9: A double request with an odd base, or an extended request whose base is not a multiple of four, reports status 10 (misaligned) and performs no access.
- R10: Status priority is disabled (01) first, then illegal operand (11), then misaligned (10). A successful access reports 00.
- R11: A port with no request reports status 00 and, for reads, zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_en_i | input | 1 | Floating-point unit enable |
| rda_req_i | input | 1 | Read port A request |
| rda_num_i | input | 5 | Read port A base register |
| rda_prec_i | input | 2 | Read port A precision code |
| rda_data_o | output | 128 | Read port A operand, right-justified |
| rda_stat_o | output | 2 | Read port A status |
| rdb_req_i | input | 1 | Read port B request |
| rdb_num_i | input | 5 | Read port B base register |
| rdb_prec_i | input | 2 | Read port B precision code |
| rdb_data_o | output | 128 | Read port B operand, right-justified |
| rdb_stat_o | output | 2 | Read port B status |
| wr_req_i | input | 1 | Write request |
| wr_num_i | input | 5 | Write base register |
| wr_prec_i | input | 2 | Write precision code |
| wr_data_i | input | 128 | Write operand, right-justified |
| wr_stat_o | output | 2 | Write status |

## Verification
Read data and all three status outputs are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples them one nanosecond later, before any rising edge. A write takes effect on the next rising edge. Its effect is checked by a read issued on the following falling edge. The same-cycle read is sampled before that edge to see the old contents. Rejected accesses are checked by reading the targeted registers back through a valid port access afterwards.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic [1:0] {
    PREC_SGL = 2'b00,
    PREC_DBL = 2'b01,
    PREC_EXT = 2'b10,
    PREC_RSV = 2'b11
  } prec_e;

  typedef enum logic [1:0] {
    ST_OK  = 2'b00,
    ST_DIS = 2'b01,
    ST_MIS = 2'b10,
    ST_ILL = 2'b11
  } stat_e;

  localparam int unsigned MAX_GRP = 4;
  localparam int unsigned CNT_W   = 3;
endpackage

// File: rtl/fprf_access_chk.sv
module fprf_access_chk
  import fprf_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             req_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] num_i,
  input  logic [1:0]       prec_i,
  output logic [1:0]       stat_o,
  output logic             go_o,
  output logic [CNT_W-1:0] cnt_o
);
  prec_e prec;
  stat_e stat;

  assign prec = prec_e'(prec_i);

  always_comb begin
    unique case (prec)
      PREC_DBL: cnt_o = CNT_W'(2);
      PREC_EXT: cnt_o = CNT_W'(4);
      default:  cnt_o = CNT_W'(1);
    endcase
  end

  // priority: disabled > illegal > misaligned
  always_comb begin
    stat = ST_OK;
    if (req_i) begin
      if (!en_i)                                 stat = ST_DIS;
      else if (prec == PREC_RSV)                 stat = ST_ILL;
      else if (prec == PREC_DBL && num_i[0])     stat = ST_MIS;
      else if (prec == PREC_EXT && |num_i[1:0])  stat = ST_MIS;
    end
  end

  assign stat_o = stat;
  assign go_o   = req_i && (stat == ST_OK);
endmodule

// File: rtl/fprf_rd_mux.sv
module fprf_rd_mux
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter int unsigned DATA_W   = REG_W * MAX_GRP
) (
  input  logic [REG_W-1:0]  rf_i [NUM_REGS],
  input  logic              go_i,
  input  logic [IDX_W-1:0]  num_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar j = 0; j < MAX_GRP; j++) begin : g_lane
    logic [IDX_W-1:0] src;
    logic             used;
    // lane 0 is the least significant word, i.e. the highest register
    assign src  = num_i + IDX_W'(cnt_i) - IDX_W'(j + 1);
    assign used = go_i && (CNT_W'(j) < cnt_i);
    assign data_o[j*REG_W +: REG_W] = used ? rf_i[src] : '0;
  end
endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned DATA_W  = REG_W * MAX_GRP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_en_i,
  input  logic              rda_req_i,
  input  logic [IDX_W-1:0]  rda_num_i,
  input  logic [1:0]        rda_prec_i,
  output logic [DATA_W-1:0] rda_data_o,
  output logic [1:0]        rda_stat_o,
  input  logic              rdb_req_i,
  input  logic [IDX_W-1:0]  rdb_num_i,
  input  logic [1:0]        rdb_prec_i,
  output logic [DATA_W-1:0] rdb_data_o,
  output logic [1:0]        rdb_stat_o,
  input  logic              wr_req_i,
  input  logic [IDX_W-1:0]  wr_num_i,
  input  logic [1:0]        wr_prec_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [1:0]        wr_stat_o
);
  logic [REG_W-1:0] rf_q [NUM_REGS];
  logic [NUM_REGS*REG_W-1:0] rf_flat;

  logic             rda_go, rdb_go, wr_go;
  logic [CNT_W-1:0] rda_cnt, rdb_cnt, wr_cnt;

  fprf_access_chk #(.IDX_W(IDX_W)) u_chk_a (
    .req_i(rda_req_i), .en_i(fp_en_i), .num_i(rda_num_i), .prec_i(rda_prec_i),
    .stat_o(rda_stat_o), .go_o(rda_go), .cnt_o(rda_cnt)
  );
  fprf_access_chk #(.IDX_W(IDX_W)) u_chk_b (
    .req_i(rdb_req_i), .en_i(fp_en_i), .num_i(rdb_num_i), .prec_i(rdb_prec_i),
    .stat_o(rdb_stat_o), .go_o(rdb_go), .cnt_o(rdb_cnt)
  );
  fprf_access_chk #(.IDX_W(IDX_W)) u_chk_w (
    .req_i(wr_req_i), .en_i(fp_en_i), .num_i(wr_num_i), .prec_i(wr_prec_i),
    .stat_o(wr_stat_o), .go_o(wr_go), .cnt_o(wr_cnt)
  );

  fprf_rd_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_mux_a (
    .rf_i(rf_q), .go_i(rda_go), .num_i(rda_num_i), .cnt_i(rda_cnt), .data_o(rda_data_o)
  );
  fprf_rd_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_mux_b (
    .rf_i(rf_q), .go_i(rdb_go), .num_i(rdb_num_i), .cnt_i(rdb_cnt), .data_o(rdb_data_o)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [IDX_W:0] off;
    logic [1:0]     lane;
    logic           hit;
    assign off  = (IDX_W+1)'(i) - {1'b0, wr_num_i};
    assign hit  = wr_go && ((IDX_W+1)'(i) >= {1'b0, wr_num_i}) && (off < (IDX_W+1)'(wr_cnt));
    assign lane = 2'(wr_cnt - CNT_W'(1) - CNT_W'(off));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  rf_q[i] <= '0;
      else if (hit) rf_q[i] <= wr_data_i[lane*REG_W +: REG_W];
    end
    assign rf_flat[i*REG_W +: REG_W] = rf_q[i];
  end

  p_dis_nowrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !fp_en_i) |=> $stable(rf_flat));

  p_ill_stat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && fp_en_i && wr_prec_i == 2'b11) |-> wr_stat_o == 2'b11);

  p_mis_stat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_req_i && fp_en_i && rda_prec_i == 2'b01 && rda_num_i[0]) |-> rda_stat_o == 2'b10);

  p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_stat_o != 2'b00) |-> rda_data_o == '0);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdb_req_i |-> (rdb_stat_o == 2'b00 && rdb_data_o == '0));

  p_sgl_land_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && fp_en_i && wr_prec_i == 2'b00) |=> rf_q[$past(wr_num_i)] == $past(wr_data_i[REG_W-1:0]));

  p_rej_nowrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && wr_stat_o != 2'b00) |=> $stable(rf_flat));
endmodule

// File: tb/sim_fprf_top.sv
module sim_fprf_top;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fp_en;
  logic         rda_req, rdb_req, wr_req;
  logic [4:0]   rda_num, rdb_num, wr_num;
  logic [1:0]   rda_prec, rdb_prec, wr_prec;
  logic [127:0] rda_data, rdb_data, wr_data;
  logic [1:0]   rda_stat, rdb_stat, wr_stat;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] m [32];

  always #4 clk = ~clk;

  fprf_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fp_en_i(fp_en),
    .rda_req_i(rda_req), .rda_num_i(rda_num), .rda_prec_i(rda_prec),
    .rda_data_o(rda_data), .rda_stat_o(rda_stat),
    .rdb_req_i(rdb_req), .rdb_num_i(rdb_num), .rdb_prec_i(rdb_prec),
    .rdb_data_o(rdb_data), .rdb_stat_o(rdb_stat),
    .wr_req_i(wr_req), .wr_num_i(wr_num), .wr_prec_i(wr_prec),
    .wr_data_i(wr_data), .wr_stat_o(wr_stat)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_rd(int n, int p);
    logic [127:0] r = '0;
    int c = (p == 0) ? 1 : (p == 1) ? 2 : 4;
    for (int j = 0; j < c; j++) r[j*32 +: 32] = m[n + c - 1 - j];
    return r;
  endfunction

  function automatic void model_wr(int n, int p, logic [127:0] d);
    int c = (p == 0) ? 1 : (p == 1) ? 2 : 4;
    for (int j = 0; j < c; j++) m[n + c - 1 - j] = d[j*32 +: 32];
  endfunction

  task automatic idle();
    rda_req = 0; rdb_req = 0; wr_req = 0;
    rda_num = 0; rdb_num = 0; wr_num = 0;
    rda_prec = 0; rdb_prec = 0; wr_prec = 0; wr_data = '0;
  endtask

  // drive at negedge, commit at posedge, return at next negedge
  task automatic do_wr(int n, int p, logic [127:0] d, string tag, logic [1:0] exp_st);
    @(negedge clk);
    wr_req = 1; wr_num = 5'(n); wr_prec = 2'(p); wr_data = d;
    #1 chk(tag, {126'b0, wr_stat}, {126'b0, exp_st});
    @(posedge clk);
    @(negedge clk);
    wr_req = 0;
    if (exp_st == 2'b00) model_wr(n, p, d);
  endtask

  task automatic rd_a(int n, int p, string tag, logic [1:0] exp_st, logic [127:0] exp_d);
    @(negedge clk);
    rda_req = 1; rda_num = 5'(n); rda_prec = 2'(p);
    #1;
    chk({tag, " stat"}, {126'b0, rda_stat}, {126'b0, exp_st});
    chk({tag, " data"}, rda_data, exp_d);
    rda_req = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i += 4) rd_a(i, 2, "R1 reset ext", 2'b00, '0);
  endtask

  task automatic t_single();
    do_wr(5, 0, 128'hFFFF_0000_1111_2222_3333_4444_DEAD_BEEF, "R5 sgl wr", 2'b00);
    rd_a(5, 0, "R2 sgl rdA", 2'b00, 128'hDEAD_BEEF);
    @(negedge clk);
    rdb_req = 1; rdb_num = 5; rdb_prec = 0;
    rda_req = 1; rda_num = 4; rda_prec = 0;
    #1;
    chk("R2 sgl rdB", rdb_data, 128'hDEAD_BEEF);
    chk("R2 rdA indep", rda_data, '0);
    rdb_req = 0; rda_req = 0;
  endtask

  task automatic t_double();
    do_wr(12, 1, 128'h0_AAAA_0001_BBBB_0002, "R5 dbl wr", 2'b00);
    rd_a(12, 1, "R3 dbl rd", 2'b00, 128'hAAAA_0001_BBBB_0002);
    rd_a(13, 0, "R3 dbl low reg", 2'b00, 128'hBBBB_0002);
  endtask

  task automatic t_ext();
    do_wr(20, 2, 128'h1111_1111_2222_2222_3333_3333_4444_4444, "R5 ext wr", 2'b00);
    rd_a(20, 2, "R4 ext rd", 2'b00, expect_rd(20, 2));
    rd_a(20, 0, "R4 ext msw", 2'b00, 128'h1111_1111);
    rd_a(23, 0, "R4 ext lsw", 2'b00, 128'h4444_4444);
    rd_a(22, 1, "R4 ext mid dbl", 2'b00, 128'h3333_3333_4444_4444);
  endtask

  task automatic t_same_cycle();
    do_wr(8, 2, 128'h0101_0101_0202_0202_0303_0303_0404_0404, "R6 pre wr", 2'b00);
    @(negedge clk);
    wr_req = 1; wr_num = 8; wr_prec = 2; wr_data = 128'hA0A0_A0A0_B0B0_B0B0_C0C0_C0C0_D0D0_D0D0;
    rda_req = 1; rda_num = 8; rda_prec = 2;
    rdb_req = 1; rdb_num = 10; rdb_prec = 1;
    #1;
    chk("R6 old rdA", rda_data, expect_rd(8, 2));
    chk("R6 old rdB", rdb_data, expect_rd(10, 1));
    @(posedge clk);
    @(negedge clk);
    wr_req = 0;
    model_wr(8, 2, wr_data);
    #1;
    chk("R6 new rdA", rda_data, expect_rd(8, 2));
    chk("R5 group same edge", rdb_data, 128'hC0C0_C0C0_D0D0_D0D0);
    rda_req = 0; rdb_req = 0;
  endtask

  task automatic t_disabled();
    fp_en = 0;
    do_wr(5, 0, 128'h1234, "R7 dis wr stat", 2'b01);
    rd_a(5, 0, "R7 dis rd", 2'b01, '0);
    fp_en = 1;
    rd_a(5, 0, "R7 no change", 2'b00, expect_rd(5, 0));
  endtask

  task automatic t_illegal();
    do_wr(0, 3, 128'hFFFF_FFFF, "R8 ill wr stat", 2'b11);
    rd_a(0, 3, "R8 ill rd", 2'b11, '0);
    rd_a(0, 0, "R8 no change", 2'b00, expect_rd(0, 0));
  endtask

  task automatic t_misalign();
    do_wr(3, 1, 128'hFFFF_FFFF_FFFF_FFFF, "R9 dbl odd wr", 2'b10);
    do_wr(6, 2, '1, "R9 ext wr", 2'b10);
    rd_a(13, 1, "R9 dbl odd rd", 2'b10, '0);
    rd_a(22, 2, "R9 ext rd", 2'b10, '0);
    rd_a(0, 2, "R9 no change lo", 2'b00, expect_rd(0, 2));
    rd_a(4, 2, "R9 no change hi", 2'b00, expect_rd(4, 2));
  endtask

  task automatic t_priority();
    fp_en = 0;
    rd_a(7, 3, "R10 dis over ill", 2'b01, '0);
    rd_a(9, 1, "R10 dis over mis", 2'b01, '0);
    fp_en = 1;
    rd_a(9, 3, "R10 ill over mis", 2'b11, '0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    rda_req = 0; rda_num = 20; rda_prec = 2;
    #1;
    chk("R11 idle stat", {126'b0, rda_stat}, '0);
    chk("R11 idle data", rda_data, '0);
    chk("R11 idle wr stat", {126'b0, wr_stat}, '0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    idle();
    fp_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_single();
    t_double();
    t_ext();
    t_same_cycle();
    t_disabled();
    t_illegal();
    t_misalign();
    t_priority();
    t_idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule